// File: doc/BRIEF.md
# NAND Flash Timing Parameter Encoder

This block turns a NAND flash device's timing limits, given in picoseconds, into the cycle counts that a static-memory controller loads into its timing registers. A host places the bus clock period (in whole nanoseconds), the bus width choice and fourteen timing limits on the inputs, then pulses `start`. The block first truncates each picosecond quantity to whole nanoseconds. It then takes the ceiling of the division by the clock period and applies a rule to each field. The rules combine a max of several inputs, a minus-one offset, a force from zero up to one, and saturation to the field width.

A single shared restoring divider does all of the arithmetic. Each of the six fields needs two divisions, one by 1000 and one by the clock period, so the run takes a fixed number of cycles. When the six fields are ready, they are packed into a 32-bit control word and a 32-bit timing word, and `done` pulses for one cycle. If the device's read cycle time is too short for the controller, the block skips the divisions. It then reports the mode as unsupported one cycle after the start.

Top module: `nand_timing_encoder`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `unsupported` are 0, and both output words are 0.
- R2: A `start` taken while idle sets `busy`. For a supported mode, `done` pulses exactly 12*(PS_W+1) clock edges after the start edge, which is 252 with the default settings, and `busy` drops on that same edge. A `start` seen while `busy` is ignored and does not change the results or the timing.
- R3: When `t_rc_min` is below 30000 ps, `done` and `unsupported` are 1 on the edge after the start edge, and both words are 0. At exactly 30000 ps the mode is supported and `unsupported` is 0.
- R4: Each conversion computes ceil(floor(ps/1000)/period). So a value of 1999 ps at 1 ns gives 1 cycle, not 2. A difference whose result would be negative clamps to 0 before the conversion.
- R5: The address-to-read field, from `t_ar_min`, is written to control bits 16:13. The command-latch-to-read field, from `t_clr_min`, is written to control bits 12:9. Each is the cycle count minus 1, with a cycle count of 0 giving 0, and each saturates at 15.
- R6: The hold field, in timing bits 23:16, is the cycle count of the largest of the data, chip-enable, command-latch, write-high, address-latch and read-high hold limits. A result of 0 becomes 1, and the field saturates at 255.
- R7: The wait field, in timing bits 15:8, is the cycle count of max(`t_rp_min`, `t_wp_min`) minus 1. A result of 0 becomes 1, and the field saturates at 255.
- R8: The setup field, in timing bits 7:0, is the cycle count minus 1 of the larger of two clamped differences: `t_cs_min`-`t_wp_min` and `t_cea_max`-`t_rea_max`. A result of 0 becomes 1, and the field saturates at 255.
- R9: The high-impedance field, in timing bits 31:24, is the cycle count of the clamped difference `t_cs_min`-`t_wp_min`, with no offset and no force to 1. It saturates at 255.
- R10: On a supported result, control bits 3:1 are all 1 (wait enable, enable and NAND device type). Bit 4 equals the `wide_bus` value captured at start, and every other control bit not listed in R5 is 0.
- R11: The output words and `unsupported` change only on an edge where `done` rises, and they hold their values between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion (taken only while idle) |
| period_ns | input | CLK_W | Bus clock period in ns, must be nonzero |
| wide_bus | input | 1 | 1 selects a 16-bit device |
| t_rc_min | input | PS_W | Minimum read cycle time, ps |
| t_ar_min | input | PS_W | Minimum address-to-read delay, ps |
| t_clr_min | input | PS_W | Minimum command-latch-to-read delay, ps |
| t_cs_min | input | PS_W | Minimum chip-select setup, ps |
| t_wp_min | input | PS_W | Minimum write pulse width, ps |
| t_dh_min | input | PS_W | Minimum data hold, ps |
| t_ch_min | input | PS_W | Minimum chip-enable hold, ps |
| t_clh_min | input | PS_W | Minimum command-latch hold, ps |
| t_wh_min | input | PS_W | Minimum write-high hold, ps |
| t_alh_min | input | PS_W | Minimum address-latch hold, ps |
| t_reh_min | input | PS_W | Minimum read-high hold, ps |
| t_rp_min | input | PS_W | Minimum read pulse width, ps |
| t_cea_max | input | PS_W | Maximum chip-enable access time, ps |
| t_rea_max | input | PS_W | Maximum read access time, ps |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the outputs are updated |
| unsupported | output | 1 | Read cycle time too short for this controller |
| ctrl_word | output | 32 | Packed control word |
| timing_word | output | 32 | Packed timing word |

## Verification
The assertions check on every cycle the relations that hold at any `done`. These are: the words are zero after an unsupported result, the hold, wait and setup fields are never 0, the fixed control bits are set and the reserved ones are clear, the words move only with `done`, and `busy` ends only through `done`. Only the bench scenarios can show the arithmetic values. These cover truncation to whole nanoseconds before the ceiling division, clamping of negative differences, saturation at 15 and 255, the exact 30000 ps boundary, the fixed latency, and that a start during a run is ignored. The bench compares these against a behavioural model on every clock.

// File: rtl/nand_timing_encoder.sv
module nand_timing_encoder #(
  parameter int PS_W        = 20,
  parameter int CLK_W       = 8,
  parameter int RC_FLOOR_PS = 30000,
  parameter int PS_PER_NS   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CLK_W-1:0] period_ns,
  input  logic             wide_bus,
  input  logic [PS_W-1:0]  t_rc_min,
  input  logic [PS_W-1:0]  t_ar_min,
  input  logic [PS_W-1:0]  t_clr_min,
  input  logic [PS_W-1:0]  t_cs_min,
  input  logic [PS_W-1:0]  t_wp_min,
  input  logic [PS_W-1:0]  t_dh_min,
  input  logic [PS_W-1:0]  t_ch_min,
  input  logic [PS_W-1:0]  t_clh_min,
  input  logic [PS_W-1:0]  t_wh_min,
  input  logic [PS_W-1:0]  t_alh_min,
  input  logic [PS_W-1:0]  t_reh_min,
  input  logic [PS_W-1:0]  t_rp_min,
  input  logic [PS_W-1:0]  t_cea_max,
  input  logic [PS_W-1:0]  t_rea_max,
  output logic             busy,
  output logic             done,
  output logic             unsupported,
  output logic [31:0]      ctrl_word,
  output logic [31:0]      timing_word
);

  localparam int NF  = 6;
  localparam int CW  = $clog2(PS_W);
  localparam logic [PS_W-1:0] RC_LIM = PS_W'(RC_FLOOR_PS);
  localparam logic [PS_W-1:0] KILO   = PS_W'(PS_PER_NS);
  localparam logic [PS_W:0]   LIM8   = (PS_W+1)'(255);
  localparam logic [PS_W:0]   LIM4   = (PS_W+1)'(15);
  localparam logic [CW-1:0]   LAST   = CW'(PS_W-1);
  localparam logic [2:0]      LAST_F = 3'(NF-1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_NEXT} state_t;

  state_t           st;
  logic [PS_W-1:0]  nxt [1:NF-1];
  logic [PS_W-1:0]  acc, rem, dsr;
  logic [CW-1:0]    cnt;
  logic [2:0]       idx;
  logic             phase;
  logic [CLK_W-1:0] per_q;
  logic             wide_q;
  logic [3:0]       f_ar, f_clr;
  logic [7:0]       f_hiz, f_hold, f_wait;

  function automatic logic [PS_W-1:0] sub0(input logic [PS_W-1:0] a, input logic [PS_W-1:0] b);
    return (a > b) ? a - b : '0;
  endfunction

  function automatic logic [PS_W-1:0] max2(input logic [PS_W-1:0] a, input logic [PS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [PS_W-1:0] cs_wp, cea_rea, hold_pk, pulse_pk, setup_pk;
  assign cs_wp    = sub0(t_cs_min, t_wp_min);
  assign cea_rea  = sub0(t_cea_max, t_rea_max);
  assign hold_pk  = max2(max2(max2(t_dh_min, t_ch_min), max2(t_clh_min, t_wh_min)),
                         max2(t_alh_min, t_reh_min));
  assign pulse_pk = max2(t_rp_min, t_wp_min);
  assign setup_pk = max2(cs_wp, cea_rea);

  logic [PS_W:0] trial, trial_sub;
  logic          ge;
  assign trial     = {rem, acc[PS_W-1]};
  assign ge        = trial >= {1'b0, dsr};
  assign trial_sub = trial - {1'b0, dsr};

  logic [PS_W:0] ceil_c, dec_c, base_c;
  logic [7:0]    sat8, sat4, field_val;
  assign ceil_c = {1'b0, acc} + {{PS_W{1'b0}}, |rem};
  assign dec_c  = (ceil_c == '0) ? '0 : ceil_c - 1'b1;
  assign base_c = (idx == 3'd2 || idx == 3'd3) ? ceil_c : dec_c;
  assign sat8   = (base_c > LIM8) ? 8'd255 : base_c[7:0];
  assign sat4   = (base_c > LIM4) ? 8'd15  : base_c[7:0];

  always_comb begin
    if (idx < 3'd2)                        field_val = sat4;
    else if (idx >= 3'd3 && sat8 == 8'd0)  field_val = 8'd1;
    else                                   field_val = sat8;
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      for (int i = 1; i < NF; i++) nxt[i] <= '0;
      acc         <= '0;
      rem         <= '0;
      dsr         <= '0;
      cnt         <= '0;
      idx         <= '0;
      phase       <= 1'b0;
      per_q       <= '0;
      wide_q      <= 1'b0;
      f_ar        <= '0;
      f_clr       <= '0;
      f_hiz       <= '0;
      f_hold      <= '0;
      f_wait      <= '0;
      done        <= 1'b0;
      unsupported <= 1'b0;
      ctrl_word   <= '0;
      timing_word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          per_q  <= period_ns;
          wide_q <= wide_bus;
          if (t_rc_min < RC_LIM) begin
            done        <= 1'b1;
            unsupported <= 1'b1;
            ctrl_word   <= '0;
            timing_word <= '0;
          end else begin
            nxt[1] <= t_clr_min;
            nxt[2] <= cs_wp;
            nxt[3] <= hold_pk;
            nxt[4] <= pulse_pk;
            nxt[5] <= setup_pk;
            acc    <= t_ar_min;
            rem    <= '0;
            dsr    <= KILO;
            cnt    <= '0;
            idx    <= '0;
            phase  <= 1'b0;
            st     <= S_DIV;
          end
        end
        S_DIV: begin
          acc <= {acc[PS_W-2:0], ge};
          rem <= ge ? trial_sub[PS_W-1:0] : trial[PS_W-1:0];
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_NEXT;
        end
        S_NEXT: begin
          cnt <= '0;
          rem <= '0;
          if (!phase) begin
            dsr   <= {{(PS_W-CLK_W){1'b0}}, per_q};
            phase <= 1'b1;
            st    <= S_DIV;
          end else begin
            phase <= 1'b0;
            case (idx)
              3'd0:    f_ar   <= field_val[3:0];
              3'd1:    f_clr  <= field_val[3:0];
              3'd2:    f_hiz  <= field_val;
              3'd3:    f_hold <= field_val;
              3'd4:    f_wait <= field_val;
              default: ;
            endcase
            if (idx == LAST_F) begin
              st          <= S_IDLE;
              done        <= 1'b1;
              unsupported <= 1'b0;
              timing_word <= {f_hiz, f_hold, f_wait, field_val};
              ctrl_word   <= {15'd0, f_ar, f_clr, 4'd0, wide_q, 3'b111, 1'b0};
            end else begin
              idx <= idx + 3'd1;
              acc <= nxt[idx + 3'd1];
              dsr <= KILO;
              st  <= S_DIV;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
  AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R2
  AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unsupported) |-> (timing_word == 32'd0 && ctrl_word == 32'd0)); // R3
  AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unsupported) |-> (timing_word[23:16] != 8'd0)); // R6
  AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unsupported) |-> (timing_word[15:8] != 8'd0)); // R7
  AST_SETUP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unsupported) |-> (timing_word[7:0] != 8'd0)); // R8
  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unsupported) |-> (ctrl_word[3:1] == 3'b111 && ctrl_word[0] == 1'b0 &&
                                ctrl_word[8:5] == 4'd0 && ctrl_word[31:17] == 15'd0)); // R10
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_word != $past(timing_word) || ctrl_word != $past(ctrl_word)) |-> done); // R11

endmodule

// File: tb/sim_nand_timing_encoder.sv
module sim_nand_timing_encoder;
  localparam int PS_W = 20;
  localparam int LAT  = 12 * (PS_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] period_ns = 8'd10;
  logic wide_bus = 1'b0;
  logic [PS_W-1:0] t_rc, t_ar, t_clr, t_cs, t_wp, t_dh, t_ch, t_clh, t_wh, t_alh, t_reh, t_rp, t_cea, t_rea;
  logic busy, done, unsupported;
  logic [31:0] ctrl_word, timing_word;

  always #10 clk = ~clk;

  nand_timing_encoder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ns(period_ns), .wide_bus(wide_bus),
    .t_rc_min(t_rc), .t_ar_min(t_ar), .t_clr_min(t_clr), .t_cs_min(t_cs), .t_wp_min(t_wp),
    .t_dh_min(t_dh), .t_ch_min(t_ch), .t_clh_min(t_clh), .t_wh_min(t_wh), .t_alh_min(t_alh),
    .t_reh_min(t_reh), .t_rp_min(t_rp), .t_cea_max(t_cea), .t_rea_max(t_rea),
    .busy(busy), .done(done), .unsupported(unsupported),
    .ctrl_word(ctrl_word), .timing_word(timing_word));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int cyc_of(input int ps, input int per);
    int ns;
    ns = ps / 1000;
    return (ns + per - 1) / per;
  endfunction
  function automatic int dif(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int minus1(input int c);
    return (c > 0) ? c - 1 : 0;
  endfunction
  function automatic int lim(input int v, input int top);
    return (v > top) ? top : v;
  endfunction
  function automatic int atleast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [31:0] exp_timing();
    int p, hiz, hold, wt, st;
    p    = int'(period_ns);
    hiz  = lim(cyc_of(dif(int'(t_cs), int'(t_wp)), p), 255);
    hold = lim(atleast1(cyc_of(mx(mx(mx(int'(t_dh), int'(t_ch)), mx(int'(t_clh), int'(t_wh))),
                                  mx(int'(t_alh), int'(t_reh))), p)), 255);
    wt   = lim(atleast1(minus1(cyc_of(mx(int'(t_rp), int'(t_wp)), p))), 255);
    st   = lim(atleast1(minus1(cyc_of(mx(dif(int'(t_cs), int'(t_wp)), dif(int'(t_cea), int'(t_rea))), p))), 255);
    return (32'(hiz) << 24) | (32'(hold) << 16) | (32'(wt) << 8) | 32'(st);
  endfunction

  function automatic logic [31:0] exp_ctrl();
    int p, ar, cl;
    p  = int'(period_ns);
    ar = lim(minus1(cyc_of(int'(t_ar), p)), 15);
    cl = lim(minus1(cyc_of(int'(t_clr), p)), 15);
    return (32'(ar) << 13) | (32'(cl) << 9) | (32'(wide_bus) << 4) | 32'h0000_000E;
  endfunction

  // behavioural reference model
  int m_cnt;
  logic m_busy, m_done, m_unsup;
  logic [31:0] m_tw, m_cw, p_tw, p_cw;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_busy <= 1'b0; m_done <= 1'b0; m_unsup <= 1'b0;
      m_tw <= '0; m_cw <= '0; p_tw <= '0; p_cw <= '0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          if (int'(t_rc) < 30000) begin
            m_done <= 1'b1; m_unsup <= 1'b1; m_tw <= '0; m_cw <= '0;
          end else begin
            m_busy <= 1'b1; m_cnt <= LAT; p_tw <= exp_timing(); p_cw <= exp_ctrl();
          end
        end
      end else if (m_cnt == 1) begin
        m_busy <= 1'b0; m_done <= 1'b1; m_unsup <= 1'b0; m_tw <= p_tw; m_cw <= p_cw;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(busy == m_busy, "R2 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R2 done", 32'(done), 32'(m_done));
      chk(unsupported == m_unsup, m_done ? "R3 unsupported" : "R11 unsupported", 32'(unsupported), 32'(m_unsup));
      chk(timing_word[7:0] == m_tw[7:0], m_done ? "R8 setup" : "R11 setup", timing_word, m_tw);
      chk(timing_word[15:8] == m_tw[15:8], m_done ? "R7 wait" : "R11 wait", timing_word, m_tw);
      chk(timing_word[23:16] == m_tw[23:16], m_done ? "R6 hold" : "R11 hold", timing_word, m_tw);
      chk(timing_word[31:24] == m_tw[31:24], m_done ? "R9 hiz" : "R11 hiz", timing_word, m_tw);
      chk(ctrl_word[16:9] == m_cw[16:9], m_done ? "R5 ctrl fields" : "R11 ctrl fields", ctrl_word, m_cw);
      chk({ctrl_word[31:17], ctrl_word[8:0]} == {m_cw[31:17], m_cw[8:0]},
          m_done ? "R10 ctrl fixed" : "R11 ctrl fixed", ctrl_word, m_cw);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic set_all(input int v);
    t_rc = 20'd30000;
    t_ar = PS_W'(v); t_clr = PS_W'(v); t_cs = PS_W'(v); t_wp = PS_W'(v);
    t_dh = PS_W'(v); t_ch = PS_W'(v); t_clh = PS_W'(v); t_wh = PS_W'(v);
    t_alh = PS_W'(v); t_reh = PS_W'(v); t_rp = PS_W'(v); t_cea = PS_W'(v); t_rea = PS_W'(v);
  endtask

  task automatic set_typical();
    period_ns = 8'd10; wide_bus = 1'b0;
    t_rc = 20'd40000; t_ar = 20'd10000; t_clr = 20'd25000; t_cs = 20'd20000; t_wp = 20'd12000;
    t_dh = 20'd5000; t_ch = 20'd5000; t_clh = 20'd5000; t_wh = 20'd10000; t_alh = 20'd5000;
    t_reh = 20'd10000; t_rp = 20'd12000; t_cea = 20'd25000; t_rea = 20'd20000;
  endtask

  initial begin
    set_all(0);
    t_rc = 20'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !unsupported, "R1 flags in reset", {29'd0, busy, done, unsupported}, 32'd0);
    chk(ctrl_word == 32'd0 && timing_word == 32'd0, "R1 words in reset", ctrl_word | timing_word, 32'd0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk(!busy && timing_word == 32'd0, "R1 after release", timing_word, 32'd0);

    // typical device, period 10 ns (R4 R5 R6 R7 R8 R9)
    set_typical();
    pulse_start();
    wait_done();
    chk(timing_word == 32'h0101_0101, "R8 typical timing word", timing_word, 32'h0101_0101);
    chk(ctrl_word == 32'h0000_040E, "R5 typical control word", ctrl_word, 32'h0000_040E);

    // start during a run is ignored (R2)
    set_typical();
    pulse_start();
    repeat (40) @(negedge clk);
    set_all(900000);
    period_ns = 8'd1;
    pulse_start();
    wait_done();
    chk(timing_word == 32'h0101_0101, "R2 start while busy ignored", timing_word, 32'h0101_0101);
    repeat (5) @(negedge clk);
    chk(!busy, "R2 no restart after ignored start", 32'(busy), 32'd0);

    // saturation at 15 and 255 (R5 R6 R7 R8 R9)
    set_all(900000);
    t_wp = 20'd0; t_rea = 20'd0;
    period_ns = 8'd1;
    pulse_start();
    wait_done();
    chk(timing_word == 32'hFFFF_FFFF, "R9 saturated timing word", timing_word, 32'hFFFF_FFFF);
    chk(ctrl_word[16:9] == 8'hFF, "R5 saturated ar/clr", 32'(ctrl_word[16:9]), 32'h0000_00FF);

    // truncation to whole ns before ceiling (R4)
    set_all(0);
    period_ns = 8'd1;
    t_ar = 20'd1999; t_clr = 20'd2999; t_dh = 20'd1999;
    pulse_start();
    wait_done();
    chk(ctrl_word[16:13] == 4'd0, "R4 truncation ar", 32'(ctrl_word[16:13]), 32'd0);
    chk(ctrl_word[12:9] == 4'd1, "R4 truncation clr", 32'(ctrl_word[12:9]), 32'd1);
    chk(timing_word[23:16] == 8'd1, "R4 truncation hold", 32'(timing_word[23:16]), 32'd1);

    // negative differences clamp to zero (R4 R9 R8)
    set_all(0);
    period_ns = 8'd5;
    t_cs = 20'd5000; t_wp = 20'd20000; t_cea = 20'd1000; t_rea = 20'd9000;
    pulse_start();
    wait_done();
    chk(timing_word[31:24] == 8'd0, "R4 clamp hiz", 32'(timing_word[31:24]), 32'd0);
    chk(timing_word[7:0] == 8'd1, "R8 clamp setup forced", 32'(timing_word[7:0]), 32'd1);

    // all zero, boundary rc = 30000 supported (R3 R6 R7 R8)
    set_all(0);
    period_ns = 8'd100;
    pulse_start();
    wait_done();
    chk(!unsupported, "R3 boundary 30000 supported", 32'(unsupported), 32'd0);
    chk(timing_word == 32'h0001_0101, "R6 zero forced to one", timing_word, 32'h0001_0101);

    // unsupported mode (R3)
    set_typical();
    t_rc = 20'd29999;
    pulse_start();
    chk(done && unsupported, "R3 unsupported flag", {30'd0, done, unsupported}, 32'd3);
    chk(timing_word == 32'd0 && ctrl_word == 32'd0, "R3 unsupported words", timing_word | ctrl_word, 32'd0);

    // wide bus bit (R10)
    set_typical();
    wide_bus = 1'b1;
    pulse_start();
    wait_done();
    chk(ctrl_word == 32'h0000_041E, "R10 wide bus control word", ctrl_word, 32'h0000_041E);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule